// File: doc/BRIEF.md
# Byte-Laned Synchronous Dual-Port Memory

This block is a synchronous true dual-port RAM with two identical ports, A and B, that share one clock. Each port samples its two select pins, its two lane enables, its read/write strobe, its address and its write data on the rising edge. The access runs in the following cycle: a write stores only the enabled byte lanes, and a read presents only the enabled lanes.

Each port has a static mode pin. With the pin low the port returns read data in the cycle right after the edge that registered the address. With the pin high the port adds one output register, which delays the data by one more edge. In that mode the outputs drive again only after the port has been selected at two sampling edges in a row.

There is no bidirectional pin. The high-impedance state is modelled by a per-lane drive flag next to the read bus, and every undriven lane reads as zero. An active-low output enable removes the drive at once, without waiting for a clock. The word count is a parameter; an address width of 14 gives the full 16384 x 16 organisation.

Top module: `dpr_sync_byte_ram`

## Requirements
- R1: A port is selected only when its `sel_n` is low and its `sel` is high at the sampling edge. An unselected edge writes nothing, and the drive flags are zero after the next edge in flow-through mode and after the edge after that in pipelined mode.
- R2: A selected write (`rnw` = 0) stores lane i only when `lane_n[i]` is low. Lane 1 is bits 15:8 and lane 0 is bits 7:0. With both `lane_n` bits high, nothing is stored.
- R3: A selected read (`rnw` = 1) sets `drive[i]` only for the lanes whose `lane_n[i]` was low. Every bit of `rdata` in a lane whose drive flag is 0 reads as 0.
- R4: With `pipe` = 0, the data at the address registered at edge k is on `rdata`, with the drive flags set, right after edge k.
- R5: With `pipe` = 1, the data at the address registered at edge k is on `rdata` right after edge k+1.
- R6: With `pipe` = 1, a read registered at edge k drives only if the port was also selected at edge k-1. After a deselect, the first selected read returns nothing.
- R7: `oe_n` high forces `drive` and `rdata` to zero at once, without a clock edge. Lowering `oe_n` restores the clocked output state.
- R8: The output in any cycle depends only on the controls registered at earlier edges. A write or idle cycle leaves the drive flags zero.
- R9: Data written on one port can be read on either port by a read registered at any later edge, including the very next one.
- R10: When both ports write the same address at the same edge, port A's enabled lanes win and port B keeps only the lanes that A did not write.
- R11: Reset is synchronous and active low. While reset is held, all drive flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| a_sel_n | input | 1 | Port A active-low select |
| a_sel | input | 1 | Port A active-high select |
| a_lane_n | input | LANES | Port A active-low lane enables, bit 1 = bits 15:8 |
| a_rnw | input | 1 | Port A 1 = read, 0 = write |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_oe_n | input | 1 | Port A asynchronous active-low output enable |
| a_pipe | input | 1 | Port A static mode, 1 = pipelined output |
| a_rdata | output | DATA_W | Port A read data, zero on undriven lanes |
| a_drive | output | LANES | Port A per-lane drive flags |
| b_sel_n | input | 1 | Port B active-low select |
| b_sel | input | 1 | Port B active-high select |
| b_lane_n | input | LANES | Port B active-low lane enables |
| b_rnw | input | 1 | Port B 1 = read, 0 = write |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_oe_n | input | 1 | Port B asynchronous active-low output enable |
| b_pipe | input | 1 | Port B static mode, 1 = pipelined output |
| b_rdata | output | DATA_W | Port B read data, zero on undriven lanes |
| b_drive | output | LANES | Port B per-lane drive flags |

## Verification
On every cycle the assertions check the drive rules that depend on control history alone. A deselect silences the outputs at the right edge in each mode, and the pipelined two-edge re-activation holds. The output enable blocks all drive, drive appears only on enabled lanes, undriven lanes read as zero, and write cycles leave the outputs quiet. The data values can only be shown by the bench scenarios, which compare against a reference array: lane-masked writes, flow-through and pipelined latency, data written on one port and read on the other, and the same-address write collision.

// File: rtl/dpr_pkg.sv
`timescale 1ns/1ps
// Shared types for the byte-laned dual-port memory.
// Assumes: one operation per port per cycle, decoded from the registered controls.
package dpr_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } port_op_e;

    typedef enum logic {
        OUT_FLOW = 1'b0,
        OUT_PIPE = 1'b1
    } out_mode_e;

    // Maps the select state and the strobe onto a port operation.
    function automatic port_op_e decode_op(input logic selected, input logic rnw);
        if (!selected) return OP_IDLE;
        return rnw ? OP_READ : OP_WRITE;
    endfunction

endpackage

// File: rtl/dpr_mem_array.sv
`timescale 1ns/1ps
// Two-port storage array with per-lane write strobes and asynchronous reads.
// Assumes: both ports share clk. When both ports write the same word at one
// edge, port A's lanes win because they are applied last.
module dpr_mem_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16,
    parameter int LANE_W = 8,
    localparam int LANES = DATA_W / LANE_W,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [LANES-1:0]  a_we,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [LANES-1:0]  b_we,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata
);

    logic [DATA_W-1:0] words [DEPTH];

    // Applies lane-masked writes: port B first, port A last so that A wins.
    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (b_we[i]) words[b_addr][i*LANE_W +: LANE_W] <= b_wdata[i*LANE_W +: LANE_W];
            if (a_we[i]) words[a_addr][i*LANE_W +: LANE_W] <= a_wdata[i*LANE_W +: LANE_W];
        end
    end

    // Read ports: the addresses arrive already registered by the port controllers.
    assign a_rdata = words[a_addr];
    assign b_rdata = words[b_addr];

endmodule

// File: rtl/dpr_port_ctrl.sv
`timescale 1ns/1ps
// One memory port: registers the inputs, decodes the operation, drives the
// lane write strobes and produces the read lanes in flow-through or pipelined
// form. In pipelined form it drives only after two consecutive selected edges.
// Assumes: pipe is static during operation; oe_n acts without a clock.
module dpr_port_ctrl
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16,
    parameter int LANE_W = 8,
    localparam int LANES = DATA_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              sel,
    input  logic [LANES-1:0]  lane_n,
    input  logic              rnw,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              oe_n,
    input  logic              pipe,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LANES-1:0]  mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [LANES-1:0]  drive
);

    port_op_e          op_q;
    logic [LANES-1:0]  lane_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              sel_hist;
    logic [LANES-1:0]  pipe_drv;
    logic [DATA_W-1:0] pipe_data;
    logic [LANES-1:0]  flow_drv;
    logic [LANES-1:0]  mode_drv;
    logic [DATA_W-1:0] mode_data;

    // Input registers, plus a record of whether the previous edge was selected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= OP_IDLE;
            lane_q   <= '0;
            addr_q   <= '0;
            wdata_q  <= '0;
            sel_hist <= 1'b0;
        end else begin
            op_q     <= decode_op(!sel_n && sel, rnw);
            lane_q   <= ~lane_n;
            addr_q   <= addr;
            wdata_q  <= wdata;
            sel_hist <= (op_q != OP_IDLE);
        end
    end

    // Output register for pipelined mode; it drives only after a second selected edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_drv  <= '0;
            pipe_data <= '0;
        end else begin
            pipe_drv  <= (op_q == OP_READ && sel_hist) ? lane_q : '0;
            pipe_data <= mem_rdata;
        end
    end

    // Array access and the mode select between the flow-through and pipelined paths.
    always_comb begin
        mem_addr  = addr_q;
        mem_wdata = wdata_q;
        mem_we    = (op_q == OP_WRITE) ? lane_q : '0;
        flow_drv  = (op_q == OP_READ) ? lane_q : '0;
        if (out_mode_e'(pipe) == OUT_PIPE) begin
            mode_drv  = pipe_drv;
            mode_data = pipe_data;
        end else begin
            mode_drv  = flow_drv;
            mode_data = mem_rdata;
        end
        drive = oe_n ? '0 : mode_drv;
    end

    // Per-lane gating: an undriven lane reads as zero.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign rdata[g*LANE_W +: LANE_W] = drive[g] ? mode_data[g*LANE_W +: LANE_W] : '0;
    end

endmodule

// File: rtl/dpr_sync_byte_ram.sv
`timescale 1ns/1ps
// Byte-laned synchronous dual-port memory: two identical port controllers
// around one shared two-port array.
// Assumes: both ports run on one clock; the depth is 2**ADDR_W words.
module dpr_sync_byte_ram #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16,
    parameter int LANE_W = 8,
    localparam int LANES = DATA_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_sel_n,
    input  logic              a_sel,
    input  logic [LANES-1:0]  a_lane_n,
    input  logic              a_rnw,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic              a_oe_n,
    input  logic              a_pipe,
    output logic [DATA_W-1:0] a_rdata,
    output logic [LANES-1:0]  a_drive,
    input  logic              b_sel_n,
    input  logic              b_sel,
    input  logic [LANES-1:0]  b_lane_n,
    input  logic              b_rnw,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    input  logic              b_oe_n,
    input  logic              b_pipe,
    output logic [DATA_W-1:0] b_rdata,
    output logic [LANES-1:0]  b_drive
);

    logic [ADDR_W-1:0] a_mem_addr, b_mem_addr;
    logic [LANES-1:0]  a_mem_we,   b_mem_we;
    logic [DATA_W-1:0] a_mem_wd,   b_mem_wd;
    logic [DATA_W-1:0] a_mem_rd,   b_mem_rd;

    dpr_port_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W)) u_port_a (
        .clk(clk), .rst_n(rst_n), .sel_n(a_sel_n), .sel(a_sel), .lane_n(a_lane_n),
        .rnw(a_rnw), .addr(a_addr), .wdata(a_wdata), .oe_n(a_oe_n), .pipe(a_pipe),
        .mem_rdata(a_mem_rd), .mem_addr(a_mem_addr), .mem_we(a_mem_we),
        .mem_wdata(a_mem_wd), .rdata(a_rdata), .drive(a_drive)
    );

    dpr_port_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W)) u_port_b (
        .clk(clk), .rst_n(rst_n), .sel_n(b_sel_n), .sel(b_sel), .lane_n(b_lane_n),
        .rnw(b_rnw), .addr(b_addr), .wdata(b_wdata), .oe_n(b_oe_n), .pipe(b_pipe),
        .mem_rdata(b_mem_rd), .mem_addr(b_mem_addr), .mem_we(b_mem_we),
        .mem_wdata(b_mem_wd), .rdata(b_rdata), .drive(b_drive)
    );

    dpr_mem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W)) u_array (
        .clk(clk),
        .a_addr(a_mem_addr), .a_we(a_mem_we), .a_wdata(a_mem_wd), .a_rdata(a_mem_rd),
        .b_addr(b_mem_addr), .b_we(b_mem_we), .b_wdata(b_mem_wd), .b_rdata(b_mem_rd)
    );

endmodule

// File: rtl/dpr_sync_byte_ram_chk.sv
`timescale 1ns/1ps
// Checker for the port-level drive rules of dpr_sync_byte_ram, bound to every instance.
// Assumes: it sees only the top-level ports; pipe is static during a run.
module dpr_sync_byte_ram_chk #(
    parameter int DATA_W = 16,
    parameter int LANE_W = 8,
    localparam int LANES = DATA_W / LANE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              a_sel_n,
    input logic              a_sel,
    input logic [LANES-1:0]  a_lane_n,
    input logic              a_rnw,
    input logic              a_oe_n,
    input logic              a_pipe,
    input logic [DATA_W-1:0] a_rdata,
    input logic [LANES-1:0]  a_drive,
    input logic              b_sel_n,
    input logic              b_sel,
    input logic [LANES-1:0]  b_lane_n,
    input logic              b_rnw,
    input logic              b_oe_n,
    input logic              b_pipe,
    input logic [DATA_W-1:0] b_rdata,
    input logic [LANES-1:0]  b_drive
);

    logic a_on, b_on;
    logic [DATA_W-1:0] a_mask, b_mask;

    assign a_on = !a_sel_n && a_sel;
    assign b_on = !b_sel_n && b_sel;

    for (genvar g = 0; g < LANES; g++) begin : g_mask
        assign a_mask[g*LANE_W +: LANE_W] = {LANE_W{a_drive[g]}};
        assign b_mask[g*LANE_W +: LANE_W] = {LANE_W{b_drive[g]}};
    end

    assert_deselect_flow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_pipe && !a_on) |=> (a_drive == '0));
    assert_deselect_pipe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (b_pipe && !b_on) ##1 b_pipe |=> (b_drive == '0));
    assert_reactivate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (b_pipe && !b_on) ##1 b_pipe ##1 b_pipe |=> (b_drive == '0));
    assert_lane_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !a_pipe |=> ((a_drive & $past(a_lane_n)) == '0));
    assert_undriven_zero_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((a_rdata & ~a_mask) == '0));
    assert_undriven_zero_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((b_rdata & ~b_mask) == '0));
    assert_oe_block_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
        a_oe_n |-> (a_drive == '0));
    assert_oe_block_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
        b_oe_n |-> (b_drive == '0));
    assert_write_quiet_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_pipe && a_on && !a_rnw) |=> (a_drive == '0));
    assert_write_quiet_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!b_pipe && b_on && !b_rnw) |=> (b_drive == '0));

endmodule

bind dpr_sync_byte_ram dpr_sync_byte_ram_chk #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .a_sel_n(a_sel_n), .a_sel(a_sel), .a_lane_n(a_lane_n), .a_rnw(a_rnw),
    .a_oe_n(a_oe_n), .a_pipe(a_pipe), .a_rdata(a_rdata), .a_drive(a_drive),
    .b_sel_n(b_sel_n), .b_sel(b_sel), .b_lane_n(b_lane_n), .b_rnw(b_rnw),
    .b_oe_n(b_oe_n), .b_pipe(b_pipe), .b_rdata(b_rdata), .b_drive(b_drive)
);

// File: tb/dpr_sync_byte_ram_bench.sv
`timescale 1ns/1ps
// Directed bench: port A in flow-through mode, port B in pipelined mode,
// compared against a reference array kept by the bench.
module dpr_sync_byte_ram_bench;

    localparam int AW = 10;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_sel_n, a_sel, a_rnw, a_oe_n, a_pipe;
    logic b_sel_n, b_sel, b_rnw, b_oe_n, b_pipe;
    logic [1:0] a_lane_n, b_lane_n, a_drive, b_drive;
    logic [AW-1:0] a_addr, b_addr;
    logic [DW-1:0] a_wdata, b_wdata, a_rdata, b_rdata;
    logic [DW-1:0] ref_mem [1 << AW];
    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    dpr_sync_byte_ram #(.ADDR_W(AW), .DATA_W(DW), .LANE_W(8)) u_dpr_sync_byte_ram (
        .clk(clk), .rst_n(rst_n),
        .a_sel_n(a_sel_n), .a_sel(a_sel), .a_lane_n(a_lane_n), .a_rnw(a_rnw),
        .a_addr(a_addr), .a_wdata(a_wdata), .a_oe_n(a_oe_n), .a_pipe(a_pipe),
        .a_rdata(a_rdata), .a_drive(a_drive),
        .b_sel_n(b_sel_n), .b_sel(b_sel), .b_lane_n(b_lane_n), .b_rnw(b_rnw),
        .b_addr(b_addr), .b_wdata(b_wdata), .b_oe_n(b_oe_n), .b_pipe(b_pipe),
        .b_rdata(b_rdata), .b_drive(b_drive)
    );

    function automatic logic [DW-1:0] lanes(input logic [DW-1:0] d, input logic [1:0] en);
        return {en[1] ? d[15:8] : 8'h00, en[0] ? d[7:0] : 8'h00};
    endfunction

    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic ref_write(input logic [AW-1:0] ad, input logic [1:0] ln, input logic [DW-1:0] d);
        if (!ln[1]) ref_mem[ad][15:8] = d[15:8];
        if (!ln[0]) ref_mem[ad][7:0]  = d[7:0];
    endtask

    task automatic a_put(input logic sn, input logic s, input logic [1:0] ln, input logic rw,
                         input logic [AW-1:0] ad, input logic [DW-1:0] d);
        a_sel_n = sn; a_sel = s; a_lane_n = ln; a_rnw = rw; a_addr = ad; a_wdata = d;
        if (!sn && s && !rw) ref_write(ad, ln, d);
    endtask

    task automatic b_put(input logic sn, input logic s, input logic [1:0] ln, input logic rw,
                         input logic [AW-1:0] ad, input logic [DW-1:0] d);
        b_sel_n = sn; b_sel = s; b_lane_n = ln; b_rnw = rw; b_addr = ad; b_wdata = d;
        if (!sn && s && !rw) ref_write(ad, ln, d);
    endtask

    task automatic a_idle(); a_put(1'b1, 1'b0, 2'b11, 1'b1, '0, '0); endtask
    task automatic b_idle(); b_put(1'b1, 1'b0, 2'b11, 1'b1, '0, '0); endtask

    task automatic t_reset();
        a_put(1'b0, 1'b1, 2'b00, 1'b1, 10'd0, '0);
        b_put(1'b0, 1'b1, 2'b00, 1'b1, 10'd0, '0);
        tick(); tick(); tick();
        check("R11 a_drive in reset", DW'(a_drive), '0);
        check("R11 b_drive in reset", DW'(b_drive), '0);
        check("R11 a_rdata in reset", a_rdata, '0);
        a_idle(); b_idle();
        rst_n = 1'b1;
        tick(); tick();
    endtask

    task automatic t_fill();
        for (int i = 0; i < 32; i++) begin
            a_put(1'b0, 1'b1, 2'b00, 1'b0, AW'(i), DW'(16'hA000 + i * 16'h0111));
            tick();
        end
        a_idle();
        tick();
    endtask

    task automatic t_flow_read();
        a_put(1'b0, 1'b1, 2'b00, 1'b1, 10'd3, '0);
        check("R8 idle before read", DW'(a_drive), '0);
        tick();
        check("R4 flow data same cycle", a_rdata, ref_mem[3]);
        check("R4 flow drive", DW'(a_drive), 16'h0003);
        a_put(1'b0, 1'b1, 2'b00, 1'b1, 10'd7, '0);
        tick();
        check("R4 flow next address", a_rdata, ref_mem[7]);
    endtask

    task automatic t_byte_write();
        a_put(1'b0, 1'b1, 2'b01, 1'b0, 10'd4, 16'h5A5A);
        tick();
        a_put(1'b0, 1'b1, 2'b10, 1'b0, 10'd5, 16'hC3C3);
        tick();
        a_put(1'b0, 1'b1, 2'b11, 1'b0, 10'd6, 16'hFFFF);
        tick();
        a_put(1'b0, 1'b1, 2'b00, 1'b1, 10'd4, '0);
        tick();
        check("R2 upper-only write", a_rdata, ref_mem[4]);
        a_put(1'b0, 1'b1, 2'b00, 1'b1, 10'd5, '0);
        tick();
        check("R2 lower-only write", a_rdata, ref_mem[5]);
        a_put(1'b0, 1'b1, 2'b00, 1'b1, 10'd6, '0);
        tick();
        check("R2 no-lane write", a_rdata, 16'hA000 + 16'd6 * 16'h0111);
    endtask

    task automatic t_byte_read();
        a_put(1'b0, 1'b1, 2'b10, 1'b1, 10'd9, '0);
        tick();
        check("R3 lower-lane drive", DW'(a_drive), 16'h0001);
        check("R3 lower-lane data", a_rdata, lanes(ref_mem[9], 2'b01));
        a_put(1'b0, 1'b1, 2'b01, 1'b1, 10'd9, '0);
        tick();
        check("R3 upper-lane data", a_rdata, lanes(ref_mem[9], 2'b10));
        a_put(1'b0, 1'b1, 2'b11, 1'b1, 10'd9, '0);
        tick();
        check("R3 no-lane drive", DW'(a_drive), '0);
        check("R3 no-lane data", a_rdata, '0);
    endtask

    task automatic t_deselect();
        a_put(1'b1, 1'b1, 2'b00, 1'b1, 10'd3, '0);
        tick();
        check("R1 sel_n high", DW'(a_drive), '0);
        a_put(1'b0, 1'b0, 2'b00, 1'b1, 10'd3, '0);
        tick();
        check("R1 sel low", DW'(a_drive), '0);
        a_put(1'b0, 1'b0, 2'b00, 1'b0, 10'd8, 16'h1234);
        tick();
        a_put(1'b0, 1'b1, 2'b00, 1'b1, 10'd8, '0);
        tick();
        check("R1 unselected write ignored", a_rdata, ref_mem[8]);
    endtask

    task automatic t_oe();
        a_put(1'b0, 1'b1, 2'b00, 1'b1, 10'd2, '0);
        tick();
        a_oe_n = 1'b1;
        #1;
        check("R7 oe_n drive off", DW'(a_drive), '0);
        check("R7 oe_n data off", a_rdata, '0);
        a_oe_n = 1'b0;
        #1;
        check("R7 oe_n restored", a_rdata, ref_mem[2]);
    endtask

    task automatic t_write_quiet();
        a_put(1'b0, 1'b1, 2'b00, 1'b0, 10'd10, 16'h0F0F);
        tick();
        check("R8 write cycle quiet", DW'(a_drive), '0);
        a_idle();
        tick();
        check("R8 idle cycle quiet", DW'(a_drive), '0);
    endtask

    task automatic t_pipe();
        b_put(1'b0, 1'b1, 2'b00, 1'b1, 10'd1, '0);
        tick();
        b_put(1'b0, 1'b1, 2'b00, 1'b1, 10'd2, '0);
        tick();
        check("R6 first selected edge silent", DW'(b_drive), '0);
        b_put(1'b0, 1'b1, 2'b00, 1'b1, 10'd3, '0);
        tick();
        check("R5 pipe drive", DW'(b_drive), 16'h0003);
        check("R5 pipe data one edge late", b_rdata, ref_mem[2]);
        b_idle();
        tick();
        check("R5 pipe following data", b_rdata, ref_mem[3]);
        b_put(1'b0, 1'b1, 2'b00, 1'b1, 10'd4, '0);
        tick();
        check("R1 pipe deselect off", DW'(b_drive), '0);
        tick();
        check("R6 re-activation wait", DW'(b_drive), '0);
        tick();
        check("R6 re-activated data", b_rdata, ref_mem[4]);
        b_idle();
        tick(); tick();
    endtask

    task automatic t_cross();
        b_put(1'b0, 1'b1, 2'b00, 1'b0, 10'd20, 16'hBEEF);
        tick();
        b_idle();
        a_put(1'b0, 1'b1, 2'b00, 1'b1, 10'd20, '0);
        tick();
        check("R9 B write seen by A next edge", a_rdata, 16'hBEEF);
        a_put(1'b0, 1'b1, 2'b00, 1'b0, 10'd21, 16'hCAFE);
        tick();
        a_idle();
        b_put(1'b0, 1'b1, 2'b00, 1'b1, 10'd21, '0);
        tick(); tick(); tick();
        check("R9 A write seen by B", b_rdata, 16'hCAFE);
        b_idle();
        tick(); tick();
    endtask

    task automatic t_collide();
        b_put(1'b0, 1'b1, 2'b00, 1'b0, 10'd30, 16'h1111);
        a_put(1'b0, 1'b1, 2'b00, 1'b0, 10'd30, 16'h2222);
        tick();
        b_put(1'b0, 1'b1, 2'b00, 1'b0, 10'd31, 16'h3344);
        a_put(1'b0, 1'b1, 2'b01, 1'b0, 10'd31, 16'hAB00);
        tick();
        b_idle();
        a_put(1'b0, 1'b1, 2'b00, 1'b1, 10'd30, '0);
        tick();
        check("R10 port A wins full word", a_rdata, 16'h2222);
        a_put(1'b0, 1'b1, 2'b00, 1'b1, 10'd31, '0);
        tick();
        check("R10 lanes merged", a_rdata, 16'hAB44);
        a_idle();
        tick();
    endtask

    initial begin
        a_oe_n = 1'b0; b_oe_n = 1'b0; a_pipe = 1'b0; b_pipe = 1'b1;
        a_idle(); b_idle();
        t_reset();
        t_fill();
        t_flow_read();
        t_byte_write();
        t_byte_read();
        t_deselect();
        t_oe();
        t_write_quiet();
        t_pipe();
        t_cross();
        t_collide();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #2_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule